// File: doc/BRIEF.md
# Credit-Based Flow-Controlled Link

This block joins a word source to a word sink through a link whose sender counts receiver buffer slots instead of waiting for a ready signal from the far end. The sender keeps a credit count. At reset the count equals the depth of the receiver's input FIFO. The sender forwards a word only while a credit is on hand, and each forwarded word spends one credit. The receiver stores each arriving word in its FIFO. Each time the sink takes a word out, the receiver raises a credit pulse for one cycle. That pulse passes through a one-cycle return register and then adds a credit back at the sender.

A credit that is on the return register can be spent in the cycle it arrives. A sender whose count is zero can therefore still forward a word in that cycle, and its count stays at zero. Words the sink does not take wait in the FIFO. Because every forwarded word has claimed a free slot first, no word is ever dropped. The upstream side is a valid/ready handshake, and the downstream side is a valid/ready handshake out of the FIFO head.

Top module: `credit_link`

## Requirements
- R1: While reset is asserted, and right after it is released, `src_ready` is 1 and `snk_valid` is 0, because the credit count is loaded with DEPTH and the FIFO is empty.
- R2: `src_ready` is 1 exactly when the credit count is non-zero or a returned credit is arriving in the current cycle. A word is accepted only when `src_valid` and `src_ready` are both 1.
- R3: Each accepted word that is not matched by an arriving credit lowers the credit count by one. With the sink stalled, exactly DEPTH words are accepted before `src_ready` falls.
- R4: Every word the sink takes (`snk_valid` and `snk_ready` both 1) produces exactly one single-cycle credit pulse at the receiver.
- R5: A credit pulse reaches the sender exactly one clock later. With no send in that cycle, it raises the count by one.
- R6: When a returned credit arrives in the same cycle as an accepted word, the count is unchanged. From zero it stays at zero, and the word is still accepted.
- R7: Words leave at `snk_data` in the order they were accepted, with none lost or duplicated. The FIFO is never written while it is full.
- R8: The credit count never goes below zero and never exceeds DEPTH.
- R9: In every cycle, the credit count plus the words held in the FIFO plus the credits in the return register equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Source word |
| src_ready | output | 1 | Sender can forward a word this cycle |
| snk_valid | output | 1 | FIFO head holds a word |
| snk_data | output | DATA_W | FIFO head word |
| snk_ready | input | 1 | Sink takes the head word |

## Verification
The bench goes after the cycle where the count is zero and a returned credit arrives. A design that ignores the arriving credit would stall there for one cycle. A design that both spends and adds the credit would let the count drift upward and then overflow the FIFO. The bench also fills the FIFO against a stalled sink to check that exactly DEPTH words are taken, which exposes an off-by-one in the reset count or in the decrement. Long random stall patterns on both sides test ordering through pointer wrap at a depth that is not a power of two. Those runs catch a lost or duplicated word and any credit leak that would break the conservation sum.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
  // Bits needed to hold values 0..n inclusive.
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
  // Bits needed to index n slots.
  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/credit_sender.sv
module credit_sender
  import credit_link_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CW = cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  input  logic          cr_arrive,
  output logic          src_ready,
  output logic          send,
  output logic [CW-1:0] credits
);
  logic [CW-1:0] credits_nx;
  logic          credits_en;

  always_comb begin
    src_ready  = (credits != '0) || cr_arrive;
    send       = src_valid && src_ready;
    credits_en = send ^ cr_arrive;
    credits_nx = credits;
    if (cr_arrive && !send)      credits_nx = credits + CW'(1);
    else if (send && !cr_arrive) credits_nx = credits - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          credits <= CW'(DEPTH);
    else if (credits_en) credits <= credits_nx;
  end
endmodule

// File: rtl/credit_fifo.sv
module credit_fifo
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  localparam int PW = idx_bits(DEPTH),
  localparam int CW = cnt_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              snk_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  output logic              pop,
  output logic              full,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr, wr_nx, rd_nx;
  logic [CW-1:0]     count_nx;

  always_comb begin
    snk_valid = (count != '0);
    full      = (count == CW'(DEPTH));
    pop       = snk_valid && snk_ready;
    snk_data  = mem[rd_ptr];
    wr_nx     = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
    rd_nx     = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
    count_nx  = count;
    if (push && !pop)      count_nx = count + CW'(1);
    else if (pop && !push) count_nx = count - CW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PW'(i))) mem[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)        wr_ptr <= wr_nx;
      if (pop)         rd_ptr <= rd_nx;
      if (push ^ pop)  count  <= count_nx;
    end
  end
endmodule

// File: rtl/credit_return.sv
module credit_return (
  input  logic clk,
  input  logic rst_n,
  input  logic cr_pulse,
  output logic cr_arrive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr_arrive <= 1'b0;
    else        cr_arrive <= cr_pulse;
  end
endmodule

// File: rtl/credit_link.sv
module credit_link
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ready
);
  localparam int CW = cnt_bits(DEPTH);

  logic          send, cr_pulse, cr_arrive, full;
  logic [CW-1:0] credits, count;

  credit_sender #(.DEPTH(DEPTH)) u_snd (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .cr_arrive(cr_arrive),
    .src_ready(src_ready), .send(send), .credits(credits)
  );

  credit_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .push(send), .push_data(src_data),
    .snk_ready(snk_ready), .snk_valid(snk_valid), .snk_data(snk_data),
    .pop(cr_pulse), .full(full), .count(count)
  );

  credit_return u_ret (
    .clk(clk), .rst_n(rst_n), .cr_pulse(cr_pulse), .cr_arrive(cr_arrive)
  );
endmodule

// File: rtl/credit_link_chk.sv
module credit_link_chk
  import credit_link_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CW = cnt_bits(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          snk_valid,
  input logic          snk_ready,
  input logic          send,
  input logic          cr_pulse,
  input logic          cr_arrive,
  input logic          full,
  input logic [CW-1:0] credits,
  input logic [CW-1:0] count
);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !send);

  assert_credit_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CW'(DEPTH));

  assert_credit_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (credits == '0) |=> (credits <= CW'(1)));

  assert_conservation_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(credits) + int'(count) + int'(cr_arrive)) == DEPTH);

  assert_pulse_per_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && snk_ready) |=> ($past(cr_pulse) && cr_arrive));

  assert_return_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_pulse && !send) |=> !(credits < $past(credits)));

  assert_spend_decrements_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !cr_arrive) |=> (credits == $past(credits) - CW'(1)));

  assert_same_cycle_reuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (send && cr_arrive) |=> $stable(credits));
endmodule

bind credit_link credit_link_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .snk_valid(snk_valid), .snk_ready(snk_ready),
  .send(send), .cr_pulse(cr_pulse), .cr_arrive(cr_arrive), .full(full),
  .credits(credits), .count(count)
);

// File: tb/credit_link_bench.sv
module credit_link_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 3;

  logic clk, rst_n;
  logic src_valid, snk_ready;
  logic [DATA_W-1:0] src_data;
  logic src_ready, snk_valid;
  logic [DATA_W-1:0] snk_data;

  int n_checks, n_fail;
  int m_cred;
  bit m_ret;
  logic [DATA_W-1:0] m_q[$];
  logic [DATA_W-1:0] next_word;
  bit done;

  credit_link #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_credit_link (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .snk_valid(snk_valid), .snk_data(snk_data),
    .snk_ready(snk_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: drive inputs, compare against model, advance model.
  task automatic step(input int vp, input int rp, input string tag);
    bit exp_rdy, s, p;
    string rtag;
    @(negedge clk);
    src_valid = ($urandom_range(99) < vp);
    snk_ready = ($urandom_range(99) < rp);
    src_data  = next_word;
    #1;
    exp_rdy = (m_cred > 0) || m_ret;
    rtag = (m_ret && m_cred == 0) ? "R6" : tag;
    check(src_ready == exp_rdy, rtag, "src_ready", src_ready, exp_rdy);
    check(snk_valid == (m_q.size() != 0), "R7", "snk_valid", snk_valid, m_q.size() != 0);
    if (m_q.size() != 0)
      check(snk_data == m_q[0], "R7", "snk_data", snk_data, m_q[0]);
    s = src_valid && exp_rdy;
    p = snk_ready && (m_q.size() != 0);
    if (s) begin m_q.push_back(next_word); next_word++; end
    if (p) void'(m_q.pop_front());
    m_cred = m_cred + int'(m_ret) - int'(s);
    m_ret  = p;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    m_cred = DEPTH; m_ret = 0; next_word = 8'h10;
    src_valid = 0; snk_ready = 0; src_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(src_ready == 1'b1, "R1", "src_ready in reset", src_ready, 1);
    check(snk_valid == 1'b0, "R1", "snk_valid in reset", snk_valid, 0);
    rst_n = 1;
    step(0, 0, "R1");
    // Fill against a stalled sink: exactly DEPTH accepted.
    for (int i = 0; i < DEPTH + 3; i++) step(100, 0, "R3");
    // Single drain, then keep offering: one credit returns a cycle later.
    step(100, 100, "R4");
    for (int i = 0; i < 3; i++) step(100, 0, "R5");
    // Saturated flow: zero count reused every cycle.
    for (int i = 0; i < 20; i++) step(100, 100, "R6");
    // Random stalls on both sides.
    for (int i = 0; i < 3000; i++) step(60, 55, "R2");
    for (int i = 0; i < 2000; i++) step(90, 20, "R2");
    for (int i = 0; i < 2000; i++) step(20, 90, "R2");
    // Drain fully with no sending: credits return up to the ceiling.
    for (int i = 0; i < DEPTH + 4; i++) step(0, 100, "R8");
    check(m_q.size() == 0 && snk_valid == 0, "R7", "empty after drain", snk_valid, 0);
    // Conservation: refill again takes exactly DEPTH words.
    for (int i = 0; i < DEPTH + 3; i++) step(100, 0, "R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule